// File: doc/BRIEF.md
# Parallel NOR Flash Command Interpreter

This block is a synthesizable behavioural model of a 16-bit parallel NOR flash. A simple synchronous bus (address, write data, write strobe, read strobe, registered read data) reaches a word array held inside the block. Writes never reach the array directly. Every modifying operation must be preceded by a two-write unlock sequence, and each write is checked on both its address and its data. After unlocking, a command write picks one of four operations: identification read, single-word program, sector erase or leaving identification mode. Ordinary reads return array contents.

The array is split into a boot region at the bottom of the map and a main region above it. Boot sectors are smaller than main sectors. A sector erase clears the sector that contains the written address. The size used depends on which region that address falls in. An erase runs as a counter that clears one word per clock while a busy output is high. The source of read data depends on the command state. A read returns the array, the identification words, or a status byte whose bit 7 reports that an erase has finished.

Top module: `nor_flash_cmd`

## Requirements
- R1: While `rst` is high at a clock edge, the block enters array-read mode: identification mode off, status byte 0x00, `busy` low, `rdata` 0x0000. Array contents are kept.
- R2: A read strobe at edge t loads `rdata` at edge t with the value selected at that time. In array-read mode this is the word at `addr`. An address at or above the capacity, BOOT_SZ*BOOT_CNT + MAIN_SZ*MAIN_CNT words, returns 0xFFFF.
- R3: An unlock sequence is write 0x00AA to 0x5555, then 0x0055 to 0x2AAA, then a command write to 0x5555. A mismatch in address or data at any of the three steps returns the block to array-read mode with identification mode off and leaves the array unchanged. A write in array-read mode that does not begin an unlock also turns identification mode off and changes nothing else.
- R4: Command 0x00A0 arms a program. The next write, at any address, stores its full 16-bit data word at that address, and the block returns to array-read mode. A program aimed at an address beyond the capacity stores nothing.
- R5: Command 0x0080 arms an erase. It must be followed by 0x00AA at 0x5555, then 0x0055 at 0x2AAA, then 0x0030 at any address. Every word of the sector holding that last address then becomes 0xFFFF, and no other word changes.
- R6: If the erase address is below BOOT_SZ*BOOT_CNT, the sector is BOOT_SZ words long. Otherwise it is MAIN_SZ words long. The sector base is the address with its low log2(size) bits cleared.
- R7: `busy` rises at the edge that accepts the 0x0030 write and stays high for exactly one cycle per word of the sector. Writes made while `busy` is high have no effect.
- R8: While a program is armed, during the erase sequence and erase, and after an erase until the next write, a read returns the status byte zero-extended to 16 bits. Bit 7 is cleared when an erase starts and set when it ends. All other status bits read 0.
- R9: After an erase, writing 0x00F0 to any address returns reads to the array.
- R10: Command 0x0090 enters identification mode. In this mode, reads decode only `addr[7:0]`: 0 returns MFR_ID, 1 returns DEV_ID, 2 returns 0x0000 (no sector protected), and any other value returns 0xFFFF. Identification mode ends on an unlock followed by command 0x00F0, or on any write that does not begin an unlock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for one bus cycle |
| rd_en | input | 1 | Read strobe for one bus cycle |
| addr | input | 16 | Word address |
| wdata | input | 16 | Write data and command codes |
| rdata | output | 16 | Registered read data |
| busy | output | 1 | High while a sector erase is running |

## Verification
Two cases are hard to reach from the ports: a write arriving while an erase is running, and a status read that shows bit 7 cleared by the start of a second erase. Both appear only several writes deep into a complete erase sequence. The stimulus completes the whole six-write erase sequence. It then counts `busy` cycles one clock at a time, issuing a status read on the first busy cycle and a fresh unlock attempt on the next three. The boot/main split is reached by erasing one boot sector and one main sector, then reading words on both sides of each boundary that were programmed beforehand.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

    localparam int BUS_AW = 16;
    localparam int BUS_DW = 16;

    typedef logic [BUS_AW-1:0] addr_t;
    typedef logic [BUS_DW-1:0] word_t;

    // unlock handshake locations and command codes
    localparam addr_t KEY_ADDR_A   = 16'h5555;
    localparam addr_t KEY_ADDR_B   = 16'h2AAA;
    localparam word_t KEY_DATA_A   = 16'h00AA;
    localparam word_t KEY_DATA_B   = 16'h0055;
    localparam word_t CMD_IDENT    = 16'h0090;
    localparam word_t CMD_ERASE_ARM = 16'h0080;
    localparam word_t CMD_PROGRAM  = 16'h00A0;
    localparam word_t CMD_LEAVE    = 16'h00F0;
    localparam word_t CMD_SECTOR   = 16'h0030;

    localparam int DONE_BIT = 7;

    typedef enum logic [3:0] {
        SQ_READY,
        SQ_KEY1,
        SQ_KEY2,
        SQ_ARMED,
        SQ_ESETUP,
        SQ_EKEY1,
        SQ_EKEY2,
        SQ_ERASING,
        SQ_EDONE
    } seq_state_e;

    typedef enum logic [1:0] {
        SRC_ARRAY,
        SRC_IDENT,
        SRC_STATUS
    } rd_src_e;

    typedef struct packed {
        logic  we;
        addr_t addr;
        word_t data;
    } wport_t;

    typedef struct packed {
        addr_t base;
        addr_t last;
    } sector_t;

    function automatic rd_src_e src_of(seq_state_e st, logic ident);
        rd_src_e r;
        case (st)
            SQ_ARMED, SQ_ESETUP, SQ_EKEY1, SQ_EKEY2,
            SQ_ERASING, SQ_EDONE: r = SRC_STATUS;
            default:              r = ident ? SRC_IDENT : SRC_ARRAY;
        endcase
        return r;
    endfunction

    function automatic word_t ident_word(logic [7:0] off, word_t mfr, word_t dev);
        word_t r;
        case (off)
            8'd0:    r = mfr;
            8'd1:    r = dev;
            8'd2:    r = '0;
            default: r = '1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/nfc_store.sv
module nfc_store
    import nfc_pkg::*;
#(
    parameter int DEPTH = 160
) (
    input  logic   clk,
    input  wport_t wp,
    input  addr_t  raddr,
    output word_t  rword
);
    localparam int    IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam addr_t LIMIT = addr_t'(DEPTH);

    word_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wp.we && (wp.addr < LIMIT)) begin
            mem[wp.addr[IW-1:0]] <= wp.data;
        end
    end

    assign rword = (raddr < LIMIT) ? mem[raddr[IW-1:0]] : '1;

endmodule

// File: rtl/nfc_eraser.sv
module nfc_eraser
    import nfc_pkg::*;
#(
    parameter int BOOT_SZ  = 8,
    parameter int BOOT_CNT = 4,
    parameter int MAIN_SZ  = 32
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  addr_t  tgt,
    output logic   busy,
    output logic   done,
    output wport_t port
);
    localparam addr_t BOOT_SPAN = addr_t'(BOOT_SZ * BOOT_CNT);
    localparam addr_t BOOT_MASK = ~addr_t'(BOOT_SZ - 1);
    localparam addr_t MAIN_MASK = ~addr_t'(MAIN_SZ - 1);
    localparam addr_t BOOT_LAST = addr_t'(BOOT_SZ - 1);
    localparam addr_t MAIN_LAST = addr_t'(MAIN_SZ - 1);

    sector_t pick;
    sector_t sec_q;
    addr_t   cnt_q;

    // region decides both the alignment and the length
    always_comb begin
        if (tgt < BOOT_SPAN) begin
            pick.base = tgt & BOOT_MASK;
            pick.last = BOOT_LAST;
        end else begin
            pick.base = tgt & MAIN_MASK;
            pick.last = MAIN_LAST;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cnt_q <= '0;
            sec_q <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            cnt_q <= '0;
            sec_q <= pick;
        end else if (busy) begin
            cnt_q <= cnt_q + addr_t'(1);
            if (cnt_q == sec_q.last) begin
                busy <= 1'b0;
            end
        end
    end

    assign done      = busy && (cnt_q == sec_q.last);
    assign port.we   = busy;
    assign port.addr = sec_q.base + cnt_q;
    assign port.data = '1;

endmodule

// File: rtl/nfc_seq.sv
module nfc_seq
    import nfc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  addr_t      addr,
    input  word_t      wdata,
    input  logic       erase_done,
    output seq_state_e state,
    output logic       id_mode,
    output logic [7:0] status,
    output logic       prog_we,
    output logic       erase_start
);
    seq_state_e nxt_st;
    logic       nxt_id;
    logic [7:0] nxt_stat;
    logic       abort;
    logic       hit_a;
    logic       hit_b;

    assign hit_a = (addr == KEY_ADDR_A) && (wdata == KEY_DATA_A);
    assign hit_b = (addr == KEY_ADDR_B) && (wdata == KEY_DATA_B);

    always_comb begin
        nxt_st      = state;
        nxt_id      = id_mode;
        nxt_stat    = status;
        prog_we     = 1'b0;
        erase_start = 1'b0;
        abort       = 1'b0;
        if (state == SQ_ERASING) begin
            // bus writes are dropped until the counter finishes
            if (erase_done) begin
                nxt_st             = SQ_EDONE;
                nxt_stat[DONE_BIT] = 1'b1;
            end
        end else if (wr_en) begin
            case (state)
                SQ_READY, SQ_EDONE: begin
                    if (hit_a) nxt_st = SQ_KEY1;
                    else       abort  = 1'b1;
                end
                SQ_KEY1: begin
                    if (hit_b) nxt_st = SQ_KEY2;
                    else       abort  = 1'b1;
                end
                SQ_KEY2: begin
                    if (addr != KEY_ADDR_A) begin
                        abort = 1'b1;
                    end else begin
                        case (wdata)
                            CMD_IDENT: begin
                                nxt_st = SQ_READY;
                                nxt_id = 1'b1;
                            end
                            CMD_LEAVE: begin
                                nxt_st = SQ_READY;
                                nxt_id = 1'b0;
                            end
                            CMD_PROGRAM: begin
                                nxt_st = SQ_ARMED;
                                nxt_id = 1'b0;
                            end
                            CMD_ERASE_ARM: begin
                                nxt_st = SQ_ESETUP;
                                nxt_id = 1'b0;
                            end
                            default: abort = 1'b1;
                        endcase
                    end
                end
                SQ_ARMED: begin
                    prog_we = 1'b1;
                    nxt_st  = SQ_READY;
                end
                SQ_ESETUP: begin
                    if (hit_a) nxt_st = SQ_EKEY1;
                    else       abort  = 1'b1;
                end
                SQ_EKEY1: begin
                    if (hit_b) nxt_st = SQ_EKEY2;
                    else       abort  = 1'b1;
                end
                SQ_EKEY2: begin
                    if (wdata == CMD_SECTOR) begin
                        erase_start        = 1'b1;
                        nxt_st             = SQ_ERASING;
                        nxt_stat[DONE_BIT] = 1'b0;
                    end else begin
                        abort = 1'b1;
                    end
                end
                default: abort = 1'b1;
            endcase
            if (abort) begin
                nxt_st = SQ_READY;
                nxt_id = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SQ_READY;
            id_mode <= 1'b0;
            status  <= 8'h00;
        end else begin
            state   <= nxt_st;
            id_mode <= nxt_id;
            status  <= nxt_stat;
        end
    end

endmodule

// File: rtl/nor_flash_cmd.sv
module nor_flash_cmd
    import nfc_pkg::*;
#(
    parameter int    BOOT_SZ  = 8,
    parameter int    BOOT_CNT = 4,
    parameter int    MAIN_SZ  = 32,
    parameter int    MAIN_CNT = 4,
    parameter word_t MFR_ID   = 16'h0037,
    parameter word_t DEV_ID   = 16'h22A5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [BUS_AW-1:0] addr,
    input  logic [BUS_DW-1:0] wdata,
    output logic [BUS_DW-1:0] rdata,
    output logic              busy
);
    localparam int DEPTH = BOOT_SZ * BOOT_CNT + MAIN_SZ * MAIN_CNT;

    seq_state_e seq_st;
    logic       id_mode;
    logic [7:0] status_q;
    logic       prog_we;
    logic       erase_start;
    logic       erase_done;
    wport_t     prog_port;
    wport_t     erase_port;
    wport_t     mem_port;
    word_t      arr_word;
    word_t      rd_next;
    rd_src_e    rd_src;

    nfc_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .addr        (addr),
        .wdata       (wdata),
        .erase_done  (erase_done),
        .state       (seq_st),
        .id_mode     (id_mode),
        .status      (status_q),
        .prog_we     (prog_we),
        .erase_start (erase_start)
    );

    nfc_eraser #(
        .BOOT_SZ  (BOOT_SZ),
        .BOOT_CNT (BOOT_CNT),
        .MAIN_SZ  (MAIN_SZ)
    ) u_erase (
        .clk   (clk),
        .rst   (rst),
        .start (erase_start),
        .tgt   (addr),
        .busy  (busy),
        .done  (erase_done),
        .port  (erase_port)
    );

    assign prog_port.we   = prog_we;
    assign prog_port.addr = addr;
    assign prog_port.data = wdata;

    // the sequencer never programs while the eraser owns the array
    assign mem_port = erase_port.we ? erase_port : prog_port;

    nfc_store #(
        .DEPTH (DEPTH)
    ) u_store (
        .clk   (clk),
        .wp    (mem_port),
        .raddr (addr),
        .rword (arr_word)
    );

    assign rd_src = src_of(seq_st, id_mode);

    always_comb begin
        case (rd_src)
            SRC_STATUS: rd_next = {8'h00, status_q};
            SRC_IDENT:  rd_next = ident_word(addr[7:0], MFR_ID, DEV_ID);
            default:    rd_next = arr_word;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_next;
        end
    end

endmodule

// File: rtl/nor_flash_cmd_chk.sv
module nor_flash_cmd_chk
    import nfc_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       wr_en,
    input word_t      wdata,
    input seq_state_e seq_st,
    input logic       id_mode,
    input logic       prog_we,
    input logic [7:0] status
);

    // R1: reset leaves the block idle in array-read mode
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (!busy && status == 8'h00 && seq_st == SQ_READY && !id_mode))
        else $error("p_reset_idle_r1");

    // R5: an erase only begins on the sector code write
    p_erase_trigger_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(wr_en) && $past(wdata) == CMD_SECTOR))
        else $error("p_erase_trigger_r5");

    // R8: completion flag clear at start, set at end
    p_flag_clear_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !status[DONE_BIT])
        else $error("p_flag_clear_r8");

    p_flag_set_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> status[DONE_BIT])
        else $error("p_flag_set_r8");

    // R7: no program write while the eraser runs
    p_no_prog_busy_r7: assert property (@(posedge clk) disable iff (rst)
        busy |-> !prog_we)
        else $error("p_no_prog_busy_r7");

    // R7: writes during an erase leave the mode untouched
    p_busy_keeps_mode_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_en) |=> $stable(id_mode))
        else $error("p_busy_keeps_mode_r7");

    // R4: a program write is single-shot
    p_prog_once_r4: assert property (@(posedge clk) disable iff (rst)
        prog_we |=> (seq_st == SQ_READY && !prog_we))
        else $error("p_prog_once_r4");

endmodule

bind nor_flash_cmd nor_flash_cmd_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .busy    (busy),
    .wr_en   (wr_en),
    .wdata   (wdata),
    .seq_st  (seq_st),
    .id_mode (id_mode),
    .prog_we (prog_we),
    .status  (status_q)
);

// File: tb/nor_flash_cmd_tb.sv
`timescale 1ns/1ps
module nor_flash_cmd_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        busy;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    nor_flash_cmd u_dut (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .busy  (busy)
    );

    typedef struct packed {
        logic [1:0]  op;
        logic [3:0]  req;
        logic [15:0] a;
        logic [15:0] v;
    } vec_t;

    localparam logic [1:0] W = 2'd1;
    localparam logic [1:0] R = 2'd2;
    localparam int NV = 64;

    localparam vec_t VEC [NV] = '{
        // program 0x0003 (R4), status while armed (R8)
        '{W, 4'd3, 16'h5555, 16'h00AA}, '{W, 4'd3, 16'h2AAA, 16'h0055},
        '{W, 4'd4, 16'h5555, 16'h00A0}, '{R, 4'd8, 16'h0003, 16'h0000},
        '{W, 4'd4, 16'h0003, 16'h1111}, '{R, 4'd4, 16'h0003, 16'h1111},
        // program 0x0009
        '{W, 4'd3, 16'h5555, 16'h00AA}, '{W, 4'd3, 16'h2AAA, 16'h0055},
        '{W, 4'd4, 16'h5555, 16'h00A0}, '{W, 4'd4, 16'h0009, 16'h2222},
        '{R, 4'd4, 16'h0009, 16'h2222},
        // program 0x0045
        '{W, 4'd3, 16'h5555, 16'h00AA}, '{W, 4'd3, 16'h2AAA, 16'h0055},
        '{W, 4'd4, 16'h5555, 16'h00A0}, '{W, 4'd4, 16'h0045, 16'h3333},
        '{R, 4'd4, 16'h0045, 16'h3333},
        // program 0x0041
        '{W, 4'd3, 16'h5555, 16'h00AA}, '{W, 4'd3, 16'h2AAA, 16'h0055},
        '{W, 4'd4, 16'h5555, 16'h00A0}, '{W, 4'd4, 16'h0041, 16'h4444},
        '{R, 4'd4, 16'h0041, 16'h4444},
        // program 0x001F
        '{W, 4'd3, 16'h5555, 16'h00AA}, '{W, 4'd3, 16'h2AAA, 16'h0055},
        '{W, 4'd4, 16'h5555, 16'h00A0}, '{W, 4'd4, 16'h001F, 16'h5555},
        '{R, 4'd4, 16'h001F, 16'h5555},
        // identification mode (R10)
        '{W, 4'd10, 16'h5555, 16'h00AA}, '{W, 4'd10, 16'h2AAA, 16'h0055},
        '{W, 4'd10, 16'h5555, 16'h0090}, '{R, 4'd10, 16'h0000, 16'h0037},
        '{R, 4'd10, 16'h0001, 16'h22A5}, '{R, 4'd10, 16'h0002, 16'h0000},
        '{R, 4'd10, 16'h0305, 16'hFFFF}, '{R, 4'd10, 16'h0F01, 16'h22A5},
        '{W, 4'd10, 16'h5555, 16'h00AA}, '{W, 4'd10, 16'h2AAA, 16'h0055},
        '{W, 4'd10, 16'h5555, 16'h00F0}, '{R, 4'd10, 16'h0003, 16'h1111},
        // identification left by a single non-unlock write
        '{W, 4'd10, 16'h5555, 16'h00AA}, '{W, 4'd10, 16'h2AAA, 16'h0055},
        '{W, 4'd10, 16'h5555, 16'h0090}, '{R, 4'd10, 16'h0100, 16'h0037},
        '{W, 4'd10, 16'h1234, 16'h00F0}, '{R, 4'd10, 16'h0003, 16'h1111},
        // R3: second unlock address wrong
        '{W, 4'd3, 16'h5555, 16'h00AA}, '{W, 4'd3, 16'h2AAB, 16'h0055},
        '{W, 4'd3, 16'h5555, 16'h00A0}, '{W, 4'd3, 16'h0003, 16'h9999},
        '{R, 4'd3, 16'h0003, 16'h1111},
        // R3: first unlock data wrong
        '{W, 4'd3, 16'h5555, 16'h00AB}, '{W, 4'd3, 16'h2AAA, 16'h0055},
        '{W, 4'd3, 16'h5555, 16'h00A0}, '{W, 4'd3, 16'h0009, 16'h7777},
        '{R, 4'd3, 16'h0009, 16'h2222},
        // R3: unknown command code
        '{W, 4'd3, 16'h5555, 16'h00AA}, '{W, 4'd3, 16'h2AAA, 16'h0055},
        '{W, 4'd3, 16'h5555, 16'h0077}, '{W, 4'd3, 16'h0009, 16'h6666},
        '{R, 4'd3, 16'h0009, 16'h2222},
        // R2: beyond capacity, program dropped and read returns ones
        '{W, 4'd2, 16'h5555, 16'h00AA}, '{W, 4'd2, 16'h2AAA, 16'h0055},
        '{W, 4'd2, 16'h5555, 16'h00A0}, '{W, 4'd2, 16'h00A0, 16'h1234},
        '{R, 4'd2, 16'h00A0, 16'hFFFF}
    };

    task automatic check(input int req, input logic [15:0] act,
                         input logic [15:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // each task starts and ends just after a falling edge
    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [15:0] q);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        q = rdata;
    endtask

    task automatic erase_at(input logic [15:0] a);
        wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h0080);
        wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(a, 16'h0030);
    endtask

    // count busy cycles; read status on the first, optionally write on the next three
    task automatic watch_busy(input bit poke, output int n, output logic [15:0] st);
        n = 0;
        st = 16'hDEAD;
        while (busy && n < 1000) begin
            n++;
            rd_en = (n == 1);
            addr  = 16'h0000;
            wr_en = 1'b0;
            if (poke && n == 2) begin wr_en = 1'b1; addr = 16'h5555; wdata = 16'h00AA; end
            if (poke && n == 3) begin wr_en = 1'b1; addr = 16'h2AAA; wdata = 16'h0055; end
            if (poke && n == 4) begin wr_en = 1'b1; addr = 16'h5555; wdata = 16'h0090; end
            @(negedge clk);
            if (n == 1) st = rdata;
            rd_en = 1'b0;
            wr_en = 1'b0;
        end
    endtask

    initial begin
        logic [15:0] q;
        logic [15:0] st;
        int          n;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: state after the power-up reset
        check(1, {15'd0, busy}, 16'h0000, "busy after reset");
        check(1, rdata, 16'h0000, "rdata after reset");

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].op == W) begin
                wr(VEC[i].a, VEC[i].v);
            end else begin
                rd(VEC[i].a, q);
                check(int'(VEC[i].req), q, VEC[i].v, $sformatf("vector %0d", i));
            end
        end

        // R5 R6 R7 R8: boot sector 1 (words 8..15)
        erase_at(16'h000C);
        watch_busy(1'b0, n, st);
        check(7, 16'(n), 16'd8, "boot erase busy cycles");
        check(8, st, 16'h0000, "status during first erase");
        rd(16'h000C, q); check(8, q, 16'h0080, "status after erase");
        wr(16'h0000, 16'h00F0);            // R9
        rd(16'h0009, q); check(9, q, 16'hFFFF, "array read after exit");
        rd(16'h0008, q); check(5, q, 16'hFFFF, "sector first word");
        rd(16'h000F, q); check(5, q, 16'hFFFF, "sector last word");
        rd(16'h0003, q); check(6, q, 16'h1111, "boot sector 0 untouched");
        rd(16'h001F, q); check(6, q, 16'h5555, "boot sector 3 untouched");
        rd(16'h0041, q); check(5, q, 16'h4444, "main word untouched");

        // R6 R7 R8: main sector at 0x40..0x5F, with writes during busy
        erase_at(16'h0047);
        watch_busy(1'b1, n, st);
        check(6, 16'(n), 16'd32, "main erase busy cycles");
        check(8, st, 16'h0000, "done flag cleared at erase start");
        rd(16'h0000, q); check(7, q, 16'h0080, "writes while busy ignored");
        wr(16'h0000, 16'h00F0);
        rd(16'h0041, q); check(5, q, 16'hFFFF, "main word 0x41 erased");
        rd(16'h0045, q); check(5, q, 16'hFFFF, "main word 0x45 erased");
        rd(16'h005F, q); check(6, q, 16'hFFFF, "main sector last word");
        rd(16'h001F, q); check(6, q, 16'h5555, "boot region untouched");
        rd(16'h0003, q); check(5, q, 16'h1111, "low word untouched");

        // R1: reset out of identification mode keeps the array
        wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h0090);
        rd(16'h0000, q); check(10, q, 16'h0037, "ident before reset");
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check(1, {15'd0, busy}, 16'h0000, "busy after second reset");
        check(1, rdata, 16'h0000, "rdata after second reset");
        rd(16'h0003, q); check(1, q, 16'h1111, "array kept, ident off");
        wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h00A0);
        rd(16'h0003, q); check(1, q, 16'h0000, "status cleared by reset");
        wr(16'h0003, 16'h1111);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule